// File: doc/BRIEF.md
# Repetition Stream Sequence Checker

This block takes a serial line stream in which every information bit is repeated across a block of 12 consecutive line bits, one bit per channel slot, and pulls one information bit out of each block. It keeps the bit in one programmable slot position and throws away the other eleven. At the nominal 600 bit/s line rate this gives a 50 bit/s recovered stream. The recovered bits are put out one at a time and are also packed into 7-bit characters.

The recovered stream is also checked against a locally generated maximal-length sequence of polynomial x^31+x^3+1. The first 31 recovered bits load the local generator. From then on the generator runs by itself, and each new recovered bit is compared with the generator's prediction. A run of clean matches declares synchronization. A cluster of mismatches withdraws it, and loading starts again. A separate flag reports any 12-bit block whose bits are not all the same.

The line clock is given as a one-cycle enable, `line_en_i`, in the system clock domain. Slot 0 is the first enabled line bit after reset. The slot counter then wraps every 12 enables.

Top module: `rep_seq_checker`

## Requirements
- R1: While `rst_ni` is low, all outputs are 0.
- R2: The slot counter counts line enables 0..11 and wraps, with slot 0 on the first enable after reset. The bit at the slot equal to `slot_sel_i` is kept, and a value of 12 to 15 selects slot 0. `kept_bit_o` and `kept_vld_o` appear one cycle after that enable, exactly once per block.
- R3: `block_err_o` pulses for one cycle, one cycle after the slot-11 enable, when the 12 bits of that block are not all equal. It stays 0 for a uniform block.
- R4: Every 7 kept bits form one character. The first kept bit of the character goes to `char_o[0]` and the last goes to `char_o[6]`. `char_vld_o` pulses one cycle after the seventh `kept_vld_o`.
- R5: After reset, and after each loss of lock, the next 31 kept bits load the reference. From then on the reference r obeys r[n] = r[n-3] xor r[n-31] and is compared with each kept bit.
- R6: If the 31 loaded bits are all zero, the load is rejected and a new 31-bit load starts with the next kept bit.
- R7: `mismatch_o` pulses one cycle after `kept_vld_o` for each compared kept bit that differs from the reference.
- R8: Before lock, any mismatch discards the reference, and loading restarts with the next kept bit.
- R9: `lock_o` rises one cycle after the 64th consecutive matching compared bit is presented.
- R10: While locked, `lock_o` falls one cycle after the compared bit that brings the mismatches among the last 64 compared bits up to 8. Loading then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_bit_i | input | 1 | Serial line data |
| line_en_i | input | 1 | One-cycle strobe per line bit |
| slot_sel_i | input | 4 | Slot index to keep (12..15 act as 0) |
| kept_bit_o | output | 1 | Recovered (decimated) bit |
| kept_vld_o | output | 1 | Strobe for kept_bit_o |
| char_o | output | 7 | Assembled character, first bit in bit 0 |
| char_vld_o | output | 1 | Strobe for char_o |
| lock_o | output | 1 | Reference sequence synchronized |
| mismatch_o | output | 1 | Compared bit differed from reference |
| block_err_o | output | 1 | Block bits were not all equal |

## Verification
The decimator is driven with blocks whose 12 slots carry different values. A wrong slot, an off-by-one slot count or bad handling of selector values 12 to 15 therefore gives a wrong kept bit. Uniform blocks of both polarities are mixed in, and these separate the disagreement flag's true and false cases. The sequence checker is fed a clean m-sequence to place the lock edge exactly. It is also fed an all-zero lead-in and an early single error, whose lock points move by a known number of bits only if zero-load rejection or reload-on-mismatch behave. Two error bursts, one of which slides out of the window before the second arrives, tell a true sliding window apart from a running total.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } trk_state_e;
endpackage

// File: rtl/rsc_slot_sel.sv
module rsc_slot_sel #(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_bit_i,
  input  logic              line_en_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  output logic              kept_bit_o,
  output logic              kept_vld_o,
  output logic              block_err_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, sel_eff;
  logic              first_q, diff_q, diff_now;

  assign sel_eff  = (slot_sel_i > LAST) ? '0 : slot_sel_i;
  assign diff_now = diff_q | (line_bit_i ^ first_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= '0;
      first_q     <= 1'b0;
      diff_q      <= 1'b0;
      kept_bit_o  <= 1'b0;
      kept_vld_o  <= 1'b0;
      block_err_o <= 1'b0;
    end else begin
      kept_vld_o  <= 1'b0;
      block_err_o <= 1'b0;
      if (line_en_i) begin
        slot_q <= (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
        if (slot_q == '0) begin
          first_q <= line_bit_i;
          diff_q  <= 1'b0;
        end else begin
          diff_q  <= diff_now;
        end
        if (slot_q == sel_eff) begin
          kept_bit_o <= line_bit_i;
          kept_vld_o <= 1'b1;
        end
        if (slot_q == LAST) block_err_o <= diff_now;
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST); // R2
  AST_KEPT_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kept_vld_o |-> $past(line_en_i)); // R2
  AST_BLKERR_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_err_o |-> ($past(line_en_i) && slot_q == '0)); // R3
endmodule

// File: rtl/rsc_char_pack.sv
module rsc_char_pack #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kept_bit_i,
  input  logic          kept_vld_i,
  output logic [CW-1:0] char_o,
  output logic          char_vld_o
);
  localparam int CNT_W = $clog2(CW);

  logic [CW-1:0]    sr_q, sr_next;
  logic [CNT_W-1:0] cnt_q;

  // newest bit enters at the top; after CW bits the first sits in bit 0
  assign sr_next = {kept_bit_i, sr_q[CW-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      char_o     <= '0;
      char_vld_o <= 1'b0;
    end else begin
      char_vld_o <= 1'b0;
      if (kept_vld_i) begin
        sr_q <= sr_next;
        if (cnt_q == CNT_W'(CW - 1)) begin
          cnt_q      <= '0;
          char_o     <= sr_next;
          char_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_CHAR_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_o |-> $past(kept_vld_i)); // R4
endmodule

// File: rtl/rsc_prbs_check.sv
module rsc_prbs_check
  import rsc_pkg::*;
#(
  parameter int DEG      = 31,
  parameter int TAP      = 3,
  parameter int LOCK_RUN = 64,
  parameter int WIN      = 64,
  parameter int ERR_LIM  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic vld_i,
  output logic lock_o,
  output logic mis_o
);
  localparam int SEED_W = $clog2(DEG + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN);
  localparam int WCNT_W = $clog2(WIN + 1);

  trk_state_e        state_q;
  logic [DEG-1:0]    lfsr_q, shift_rx, shift_ref;
  logic [SEED_W-1:0] seed_cnt_q;
  logic [RUN_W-1:0]  run_q;
  logic [WIN-1:0]    hist_q;
  logic [WCNT_W-1:0] wcnt_q, wcnt_n;
  logic              pred, mis;

  assign pred      = lfsr_q[TAP-1] ^ lfsr_q[DEG-1];
  assign mis       = bit_i ^ pred;
  assign shift_rx  = {lfsr_q[DEG-2:0], bit_i};
  assign shift_ref = {lfsr_q[DEG-2:0], pred};
  assign wcnt_n    = wcnt_q + WCNT_W'(mis) - WCNT_W'(hist_q[WIN-1]);
  assign lock_o    = (state_q == ST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SEED;
      lfsr_q     <= '0;
      seed_cnt_q <= '0;
      run_q      <= '0;
      hist_q     <= '0;
      wcnt_q     <= '0;
      mis_o      <= 1'b0;
    end else begin
      mis_o <= 1'b0;
      if (vld_i) begin
        unique case (state_q)
          ST_SEED: begin
            lfsr_q <= shift_rx;
            if (seed_cnt_q == SEED_W'(DEG - 1)) begin
              seed_cnt_q <= '0;
              run_q      <= '0;
              if (shift_rx != '0) state_q <= ST_HUNT;
            end else begin
              seed_cnt_q <= seed_cnt_q + SEED_W'(1);
            end
          end
          ST_HUNT: begin
            mis_o <= mis;
            if (mis) begin
              state_q    <= ST_SEED;
              seed_cnt_q <= '0;
            end else begin
              lfsr_q <= shift_ref;
              if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                state_q <= ST_LOCK;
                hist_q  <= '0;
                wcnt_q  <= '0;
              end else begin
                run_q <= run_q + RUN_W'(1);
              end
            end
          end
          ST_LOCK: begin
            mis_o  <= mis;
            lfsr_q <= shift_ref;
            hist_q <= {hist_q[WIN-2:0], mis};
            if (wcnt_n >= WCNT_W'(ERR_LIM)) begin
              state_q    <= ST_SEED;
              seed_cnt_q <= '0;
            end else begin
              wcnt_q <= wcnt_n;
            end
          end
          default: state_q <= ST_SEED;
        endcase
      end
    end
  end

  AST_HUNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |-> (lfsr_q != '0)); // R6
  AST_MIS_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_o |-> $past(vld_i)); // R7
  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(state_q) == ST_HUNT && !mis_o)); // R9
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q < WCNT_W'(ERR_LIM)); // R10
endmodule

// File: rtl/rep_seq_checker.sv
module rep_seq_checker #(
  parameter int SLOTS    = 12,
  parameter int CW       = 7,
  parameter int DEG      = 31,
  parameter int TAP      = 3,
  parameter int LOCK_RUN = 64,
  parameter int WIN      = 64,
  parameter int ERR_LIM  = 8,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_bit_i,
  input  logic              line_en_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  output logic              kept_bit_o,
  output logic              kept_vld_o,
  output logic [CW-1:0]     char_o,
  output logic              char_vld_o,
  output logic              lock_o,
  output logic              mismatch_o,
  output logic              block_err_o
);
  rsc_slot_sel #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_bit_i  (line_bit_i),
    .line_en_i   (line_en_i),
    .slot_sel_i  (slot_sel_i),
    .kept_bit_o  (kept_bit_o),
    .kept_vld_o  (kept_vld_o),
    .block_err_o (block_err_o)
  );

  rsc_char_pack #(.CW(CW)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kept_bit_i (kept_bit_o),
    .kept_vld_i (kept_vld_o),
    .char_o     (char_o),
    .char_vld_o (char_vld_o)
  );

  rsc_prbs_check #(
    .DEG(DEG), .TAP(TAP), .LOCK_RUN(LOCK_RUN), .WIN(WIN), .ERR_LIM(ERR_LIM)
  ) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (kept_bit_o),
    .vld_i  (kept_vld_o),
    .lock_o (lock_o),
    .mis_o  (mismatch_o)
  );
endmodule

// File: tb/rep_seq_checker_bench.sv
module rep_seq_checker_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_bit = 1'b0;
  logic       line_en = 1'b0;
  logic [3:0] slot_sel = 4'd0;
  logic       kept_bit_o, kept_vld_o, char_vld_o, lock_o, mismatch_o, block_err_o;
  logic [6:0] char_o;

  int checks = 0;
  int errors = 0;

  logic [255:0] seq;
  logic       b_kb, b_be, b_cv, b_lk, b_mm;
  int         b_kcnt;
  logic [6:0] b_ch;

  always #(CLK_PERIOD/2) clk = ~clk;

  rep_seq_checker u_rep_seq_checker (
    .clk_i(clk), .rst_ni(rst_n), .line_bit_i(line_bit), .line_en_i(line_en),
    .slot_sel_i(slot_sel), .kept_bit_o(kept_bit_o), .kept_vld_o(kept_vld_o),
    .char_o(char_o), .char_vld_o(char_vld_o), .lock_o(lock_o),
    .mismatch_o(mismatch_o), .block_err_o(block_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; line_en = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {20'd0, kept_bit_o, kept_vld_o, char_o, char_vld_o, lock_o, mismatch_o, block_err_o}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // one 12-slot block; captures outputs around the selected slot
  task automatic send_block(input logic [11:0] pat, input int eff);
    b_kcnt = 0; b_be = 1'b0;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk) line_bit = pat[s]; line_en = 1'b1;
      @(negedge clk) line_en = 1'b0;
      if (kept_vld_o) begin b_kcnt++; b_kb = kept_bit_o; end
      if (s == 11) b_be = block_err_o;
      @(negedge clk);
      if (s == eff) begin
        b_cv = char_vld_o; b_ch = char_o; b_lk = lock_o; b_mm = mismatch_o;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic err_at(input int i);
    return ((i >= 96 && i <= 102) || (i >= 173 && i <= 176) || (i >= 180 && i <= 183));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [30:0] sd;
    logic [6:0]  cexp;
    int          kidx;
    sd = 31'h4B3C2D1E;
    for (int n = 0; n < 256; n++)
      seq[n] = (n < 31) ? sd[n] : (seq[n-3] ^ seq[n-31]);

    // Phase A: slot sweep, block flag, character packing
    do_reset();
    kidx = 0; cexp = '0;
    for (int sel = 0; sel < 16; sel++) begin
      for (int blk = 0; blk < 3; blk++) begin
        logic [11:0] pat;
        int eff;
        pat = 12'((sel * 613 + blk * 1877 + 91) ^ (blk * 2730));
        if (blk == 2) pat = sel[0] ? 12'hFFF : 12'h000;
        eff = (sel > 11) ? 0 : sel;
        slot_sel = 4'(sel);
        send_block(pat, eff);
        chk("R2 one kept bit per block", 32'(b_kcnt), 32'd1);
        chk("R2 kept slot value", {31'd0, b_kb}, {31'd0, pat[eff]});
        chk("R3 block disagreement", {31'd0, b_be}, {31'd0, (pat != 12'h000 && pat != 12'hFFF)});
        cexp[kidx] = pat[eff];
        kidx++;
        if (kidx == 7) begin
          chk("R4 char strobe", {31'd0, b_cv}, 32'd1);
          chk("R4 char value", {25'd0, b_ch}, {25'd0, cexp});
          kidx = 0;
        end else begin
          chk("R4 no char strobe", {31'd0, b_cv}, 32'd0);
        end
      end
    end

    // Phase B: lock on clean sequence, window-based loss
    do_reset();
    slot_sel = 4'd5;
    for (int i = 0; i <= 183; i++) begin
      logic bv;
      bv = seq[i] ^ err_at(i);
      send_block(bv ? 12'hFFF : 12'h000, 5);
      chk("R9 R10 lock", {31'd0, b_lk}, {31'd0, (i >= 94 && i <= 182)});
      chk("R5 R7 mismatch", {31'd0, b_mm}, {31'd0, (i >= 31) ? err_at(i) : 1'b0});
    end

    // Phase C: all-zero load rejected
    do_reset();
    slot_sel = 4'd11;
    for (int i = 0; i < 31; i++) begin
      send_block(12'h000, 11);
      chk("R6 zero lead-in lock", {31'd0, b_lk}, 32'd0);
      chk("R6 zero lead-in mismatch", {31'd0, b_mm}, 32'd0);
    end
    for (int i = 0; i <= 94; i++) begin
      send_block(seq[i] ? 12'hFFF : 12'h000, 11);
      chk("R6 lock after rejected zero load", {31'd0, b_lk}, {31'd0, (i >= 94)});
      chk("R6 no mismatch", {31'd0, b_mm}, 32'd0);
    end

    // Phase D: pre-lock mismatch forces reload (selector 13 acts as slot 0)
    do_reset();
    slot_sel = 4'd13;
    for (int i = 0; i <= 126; i++) begin
      logic bv;
      bv = seq[i] ^ (i == 31);
      send_block(bv ? 12'hFFF : 12'h000, 0);
      chk("R8 lock after reload", {31'd0, b_lk}, {31'd0, (i >= 126)});
      chk("R8 mismatch pulse", {31'd0, b_mm}, {31'd0, (i == 31)});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule